// File: doc/BRIEF.md
# Speculative memory operand renaming unit

This unit sits in the rename stage and sees one decoded instruction per cycle. It guesses that a load reads the value written by an earlier store when both name the same symbolic address. The symbolic address is the base register name, the index register name, the scale and the displacement, taken before any address is computed. On a guess the load receives the store's data tag and the store's sequence number, so the load can skip the trip through memory.

Stack operands are tracked through a running stack pointer delta. Push, pop, call and return move the delta, and a stack-based key holds the adjusted offset, so a value pushed before a call is found again at its new offset from the stack pointer. Register writes, non-tracked stack pointer changes and store retirement remove entries. A verification port later gets the real addresses. It raises a one-cycle flush request, and empties the table, when a forward was wrong or when a missed aliasing case was really the same address.

Top module: `memren_unit`

## Requirements
- R1: Only operands in general purpose registers with size code 2 (32-bit) or 3 (64-bit) create or hit an entry. Size codes 0 and 1, or `in_gpr`=0, neither allocate nor hit.
- R2: Only addressing mode code 0 (base with optional index) is eligible. Code 1 (absolute) and code 2 (instruction-pointer relative) never allocate or hit.
- R3: The displacement must be a multiple of 8 when `in_mode64`=1 and a multiple of 4 when it is 0. Otherwise the access neither allocates nor hits.
- R4: A load (op 1) whose base, index enable, index, scale and displacement equal those of a live store (op 2) hits, and returns the store's tag and sequence number.
- R5: A load that differs in any key field from every live entry misses. Different base register names are never treated as the same address.
- R6: Stack register is name 4. Push (op 4) and call (op 6) lower the delta by the word size (8 or 4), and pop (op 5) and return (op 7) raise it. Push stores at the new top, pop loads from the old top, and stack-based keys use displacement plus delta.
- R7: A stack pointer copy (`in_sp_copy`), or a write to register 4 by an op other than 4 to 7, removes every stack-based entry and leaves the others.
- R8: A write to a register (`in_wr_en`, `in_wr_reg`) removes every entry that names it as base or index.
- R9: A read-modify-write (op 3) hits with the old tag and then replaces the entry's tag and sequence number. Back-to-back read-modify-writes chain one per cycle.
- R10: A store to a key that is already live updates that entry instead of allocating a second one. When the table is full, slots are replaced in round-robin order starting from slot 0 after reset or clear.
- R11: A verification with `vfy_fwd`=1 and different addresses, or with `vfy_fwd`=0 and equal addresses, raises `flush` for one cycle and empties the table at the same edge. All other cases leave the table untouched.
- R12: A retire report (`ret_valid`, `ret_seq`) removes the entry created by that store sequence number.
- R13: `hit`, `hit_tag` and `hit_seq` are registered and appear one cycle after the instruction. After reset, `hit` and `flush` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Decoded instruction valid |
| in_op | input | 3 | Op: 0 other, 1 load, 2 store, 3 read-modify-write, 4 push, 5 pop, 6 call, 7 return |
| in_mode64 | input | 1 | 64-bit mode (word size 8, otherwise 4) |
| in_gpr | input | 1 | Operand register is general purpose |
| in_size | input | 2 | Operand size code: 0 8-bit, 1 16-bit, 2 32-bit, 3 64-bit |
| in_am | input | 2 | Addressing mode: 0 base(+index), 1 absolute, 2 instruction-pointer relative |
| in_base | input | REG_W | Base register name |
| in_idx_en | input | 1 | Index register used |
| in_idx | input | REG_W | Index register name |
| in_scale | input | 2 | Index scale code |
| in_disp | input | DISP_W | Signed displacement |
| in_tag | input | TAG_W | Data tag of store value |
| in_seq | input | SEQ_W | Sequence number of this instruction |
| in_wr_en | input | 1 | Instruction writes a register |
| in_wr_reg | input | REG_W | Register written |
| in_sp_copy | input | 1 | Instruction copies the stack pointer elsewhere |
| ret_valid | input | 1 | A store retired and drained |
| ret_seq | input | SEQ_W | Sequence number of that store |
| vfy_valid | input | 1 | Verification request |
| vfy_fwd | input | 1 | The load was forwarded |
| vfy_st_addr | input | ADDR_W | Real store address |
| vfy_ld_addr | input | ADDR_W | Real load address |
| hit | output | 1 | Forward predicted for last cycle's instruction |
| hit_tag | output | TAG_W | Forwarded data tag |
| hit_seq | output | SEQ_W | Sequence number of the supplying store |
| flush | output | 1 | Mispredict flush request |

## Verification
On every cycle the assertions check that at most one entry matches a key, that a clear leaves no live entry, that stack invalidation leaves no stack-based entry, that every flush comes from a verification request, and that no hit follows an ineligible size, register class or addressing mode. Only the bench scenarios can show the values that are forwarded. These are the push, call and load sequence against the delta, read-modify-write chaining, round-robin eviction order, retirement and register-write removal, and the random store, load and read-modify-write mix checked against a per-key model.

// File: rtl/memren_pkg.sv
// Shared encodings for the memory renaming unit.
// Assumes: op and addressing-mode codes are fixed by the decoder.
package memren_pkg;
    typedef enum logic [2:0] {
        OP_OTHER = 3'd0, OP_LOAD = 3'd1, OP_STORE = 3'd2, OP_RMW = 3'd3,
        OP_PUSH  = 3'd4, OP_POP  = 3'd5, OP_CALL  = 3'd6, OP_RET = 3'd7
    } mr_op_e;

    typedef enum logic [1:0] {
        AM_BASE = 2'd0, AM_ABS = 2'd1, AM_IPREL = 2'd2, AM_RSVD = 2'd3
    } mr_am_e;

    localparam logic [1:0] SZ_32 = 2'd2;
    localparam logic [1:0] SZ_64 = 2'd3;
endpackage

// File: rtl/memren_keygen.sv
// Key generator: checks eligibility, forms the symbolic key and keeps the
// stack pointer delta. It also decodes the invalidation events.
// Assumes: at most one instruction per cycle, with the delta wrapping at DISP_W bits.
module memren_keygen
    import memren_pkg::*;
#(
    parameter int REG_W  = 4,
    parameter int DISP_W = 16,
    parameter logic [REG_W-1:0] SP_ID = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        in_op,
    input  logic              in_mode64,
    input  logic              in_gpr,
    input  logic [1:0]        in_size,
    input  logic [1:0]        in_am,
    input  logic [REG_W-1:0]  in_base,
    input  logic              in_idx_en,
    input  logic [REG_W-1:0]  in_idx,
    input  logic [1:0]        in_scale,
    input  logic [DISP_W-1:0] in_disp,
    input  logic              in_wr_en,
    input  logic [REG_W-1:0]  in_wr_reg,
    input  logic              in_sp_copy,
    output logic              lk_req,
    output logic              al_req,
    output logic [REG_W-1:0]  k_base,
    output logic              k_idx_en,
    output logic [REG_W-1:0]  k_idx,
    output logic [1:0]        k_scale,
    output logic [DISP_W-1:0] k_off,
    output logic              inv_sp,
    output logic              inv_reg_en,
    output logic [REG_W-1:0]  inv_reg
);
    mr_op_e            op;
    logic              stk_op, size_ok, disp_ok, mem_ok;
    logic [DISP_W-1:0] step, sp_delta, mem_off;

    assign op      = mr_op_e'(in_op);
    assign stk_op  = (op == OP_PUSH) || (op == OP_POP) || (op == OP_CALL) || (op == OP_RET);
    assign size_ok = in_gpr && ((in_size == SZ_32) || (in_size == SZ_64));
    assign disp_ok = in_mode64 ? (in_disp[2:0] == 3'd0) : (in_disp[1:0] == 2'd0);
    assign mem_ok  = in_valid && size_ok && disp_ok && (mr_am_e'(in_am) == AM_BASE);
    assign step    = in_mode64 ? DISP_W'(8) : DISP_W'(4);
    assign mem_off = (in_base == SP_ID) ? in_disp + sp_delta : in_disp;

    // Form the key and the lookup and allocate requests for this instruction.
    always_comb begin
        lk_req   = 1'b0;
        al_req   = 1'b0;
        k_base   = in_base;
        k_idx_en = in_idx_en;
        k_idx    = in_idx_en ? in_idx : '0;
        k_scale  = in_idx_en ? in_scale : 2'd0;
        k_off    = mem_off;
        case (op)
            OP_LOAD:  lk_req = mem_ok;
            OP_STORE: al_req = mem_ok;
            OP_RMW: begin
                lk_req = mem_ok;
                al_req = mem_ok;
            end
            OP_PUSH, OP_POP: begin
                lk_req   = in_valid && size_ok && (op == OP_POP);
                al_req   = in_valid && size_ok && (op == OP_PUSH);
                k_base   = SP_ID;
                k_idx_en = 1'b0;
                k_idx    = '0;
                k_scale  = 2'd0;
                k_off    = (op == OP_PUSH) ? sp_delta - step : sp_delta;
            end
            default: ;
        endcase
    end

    // Track the stack pointer movement made by push, pop, call and return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_delta <= '0;
        end else if (in_valid) begin
            if (op == OP_PUSH || op == OP_CALL) sp_delta <= sp_delta - step;
            else if (op == OP_POP || op == OP_RET) sp_delta <= sp_delta + step;
        end
    end

    assign inv_sp     = in_valid && (in_sp_copy || (in_wr_en && in_wr_reg == SP_ID && !stk_op));
    assign inv_reg_en = in_valid && in_wr_en && (in_wr_reg != SP_ID);
    assign inv_reg    = in_wr_reg;
endmodule

// File: rtl/memren_table.sv
// Fully associative tracking table for symbolic store addresses.
// Lookup is combinational on the registered state. Removal is applied before
// allocation in the same cycle, and a clear overrides everything.
// Assumes: N_ENT >= 2 and at most one allocation per cycle.
module memren_table #(
    parameter int N_ENT  = 8,
    parameter int REG_W  = 4,
    parameter int DISP_W = 16,
    parameter int TAG_W  = 7,
    parameter int SEQ_W  = 6,
    parameter logic [REG_W-1:0] SP_ID = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic              al_req,
    input  logic [REG_W-1:0]  k_base,
    input  logic              k_idx_en,
    input  logic [REG_W-1:0]  k_idx,
    input  logic [1:0]        k_scale,
    input  logic [DISP_W-1:0] k_off,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [SEQ_W-1:0]  wr_seq,
    input  logic              inv_sp,
    input  logic              inv_reg_en,
    input  logic [REG_W-1:0]  inv_reg,
    input  logic              ret_valid,
    input  logic [SEQ_W-1:0]  ret_seq,
    input  logic              clr,
    output logic              lk_hit,
    output logic [TAG_W-1:0]  lk_tag,
    output logic [SEQ_W-1:0]  lk_seq
);
    localparam int IDX_W = $clog2(N_ENT);

    logic [N_ENT-1:0]  e_vld, match, drop, sp_live;
    logic [REG_W-1:0]  e_base  [N_ENT];
    logic              e_ixen  [N_ENT];
    logic [REG_W-1:0]  e_idx   [N_ENT];
    logic [1:0]        e_scale [N_ENT];
    logic [DISP_W-1:0] e_off   [N_ENT];
    logic [TAG_W-1:0]  e_tag   [N_ENT];
    logic [SEQ_W-1:0]  e_seq   [N_ENT];
    logic [IDX_W-1:0]  rr, m_idx, w_idx;
    logic              any;

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        assign match[g] = e_vld[g] && e_base[g] == k_base && e_ixen[g] == k_idx_en
                       && e_idx[g] == k_idx && e_scale[g] == k_scale && e_off[g] == k_off;
        assign drop[g]  = (ret_valid && e_seq[g] == ret_seq)
                       || (inv_sp && e_base[g] == SP_ID)
                       || (inv_reg_en && (e_base[g] == inv_reg || (e_ixen[g] && e_idx[g] == inv_reg)));
        assign sp_live[g] = e_vld[g] && e_base[g] == SP_ID;
    end

    // Encode the matching slot (at most one is expected).
    always_comb begin
        m_idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) if (match[i]) m_idx = IDX_W'(i);
    end

    assign any    = |match;
    assign w_idx  = any ? m_idx : rr;
    assign lk_hit = lk_req && any;
    assign lk_tag = e_tag[m_idx];
    assign lk_seq = e_seq[m_idx];

    // Valid bits and round-robin pointer: clear, then removal, then allocation.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            e_vld <= '0;
            rr    <= '0;
        end else begin
            e_vld <= e_vld & ~drop;
            if (al_req) begin
                e_vld[w_idx] <= 1'b1;
                if (!any) rr <= (rr == IDX_W'(N_ENT - 1)) ? '0 : rr + 1'b1;
            end
        end
    end

    // Entry payload written on allocation or overwrite.
    always_ff @(posedge clk) begin
        if (al_req) begin
            e_base[w_idx]  <= k_base;
            e_ixen[w_idx]  <= k_idx_en;
            e_idx[w_idx]   <= k_idx;
            e_scale[w_idx] <= k_scale;
            e_off[w_idx]   <= k_off;
            e_tag[w_idx]   <= wr_tag;
            e_seq[w_idx]   <= wr_seq;
        end
    end

    a_r10_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
    a_r11_clear_empty: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (e_vld == '0));
    a_r7_sp_entries_gone: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_sp && !al_req) |=> (sp_live == '0));
endmodule

// File: rtl/memren_verify.sv
// Verification checker: compares the real store and load addresses after
// execution, clears the table and raises a registered one-cycle flush on a
// wrong guess.
// Assumes: one verification request per cycle.
module memren_verify #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vfy_valid,
    input  logic              vfy_fwd,
    input  logic [ADDR_W-1:0] vfy_st_addr,
    input  logic [ADDR_W-1:0] vfy_ld_addr,
    output logic              clr,
    output logic              flush
);
    logic same;
    assign same = (vfy_st_addr == vfy_ld_addr);
    assign clr  = vfy_valid && (vfy_fwd ? !same : same);

    // Register the flush request for one cycle per mispredict.
    always_ff @(posedge clk) begin
        if (!rst_n) flush <= 1'b0;
        else        flush <= clr;
    end

    a_r11_flush_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> $past(vfy_valid));
endmodule

// File: rtl/memren_unit.sv
// Top of the speculative memory operand renaming unit: key generation,
// tracking table and address verification, with registered hit outputs.
// Assumes: one decoded instruction per cycle and the stack register named SP_ID.
module memren_unit
    import memren_pkg::*;
#(
    parameter int N_ENT  = 8,
    parameter int REG_W  = 4,
    parameter int DISP_W = 16,
    parameter int TAG_W  = 7,
    parameter int SEQ_W  = 6,
    parameter int ADDR_W = 32,
    parameter logic [REG_W-1:0] SP_ID = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        in_op,
    input  logic              in_mode64,
    input  logic              in_gpr,
    input  logic [1:0]        in_size,
    input  logic [1:0]        in_am,
    input  logic [REG_W-1:0]  in_base,
    input  logic              in_idx_en,
    input  logic [REG_W-1:0]  in_idx,
    input  logic [1:0]        in_scale,
    input  logic [DISP_W-1:0] in_disp,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [SEQ_W-1:0]  in_seq,
    input  logic              in_wr_en,
    input  logic [REG_W-1:0]  in_wr_reg,
    input  logic              in_sp_copy,
    input  logic              ret_valid,
    input  logic [SEQ_W-1:0]  ret_seq,
    input  logic              vfy_valid,
    input  logic              vfy_fwd,
    input  logic [ADDR_W-1:0] vfy_st_addr,
    input  logic [ADDR_W-1:0] vfy_ld_addr,
    output logic              hit,
    output logic [TAG_W-1:0]  hit_tag,
    output logic [SEQ_W-1:0]  hit_seq,
    output logic              flush
);
    logic              lk_req, al_req, k_idx_en, inv_sp, inv_reg_en, clr, t_hit;
    logic [REG_W-1:0]  k_base, k_idx, inv_reg;
    logic [1:0]        k_scale;
    logic [DISP_W-1:0] k_off;
    logic [TAG_W-1:0]  t_tag;
    logic [SEQ_W-1:0]  t_seq;

    memren_keygen #(.REG_W(REG_W), .DISP_W(DISP_W), .SP_ID(SP_ID)) u_key (
        .clk, .rst_n, .in_valid, .in_op, .in_mode64, .in_gpr, .in_size, .in_am,
        .in_base, .in_idx_en, .in_idx, .in_scale, .in_disp, .in_wr_en, .in_wr_reg,
        .in_sp_copy, .lk_req, .al_req, .k_base, .k_idx_en, .k_idx, .k_scale, .k_off,
        .inv_sp, .inv_reg_en, .inv_reg);

    memren_table #(.N_ENT(N_ENT), .REG_W(REG_W), .DISP_W(DISP_W), .TAG_W(TAG_W),
                   .SEQ_W(SEQ_W), .SP_ID(SP_ID)) u_tbl (
        .clk, .rst_n, .lk_req, .al_req, .k_base, .k_idx_en, .k_idx, .k_scale, .k_off,
        .wr_tag(in_tag), .wr_seq(in_seq), .inv_sp, .inv_reg_en, .inv_reg,
        .ret_valid, .ret_seq, .clr, .lk_hit(t_hit), .lk_tag(t_tag), .lk_seq(t_seq));

    memren_verify #(.ADDR_W(ADDR_W)) u_vfy (
        .clk, .rst_n, .vfy_valid, .vfy_fwd, .vfy_st_addr, .vfy_ld_addr, .clr, .flush);

    // Register the lookup result toward the rename outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit     <= 1'b0;
            hit_tag <= '0;
            hit_seq <= '0;
        end else begin
            hit     <= t_hit;
            hit_tag <= t_tag;
            hit_seq <= t_seq;
        end
    end

    a_r1_hit_needs_size: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(in_gpr && in_size[1]));
    a_r2_hit_needs_base_mode: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(in_am == AM_BASE || in_op == OP_POP));
endmodule

// File: tb/memren_unit_tb.sv
module memren_unit_tb;
    logic        clk = 0, rst_n = 0;
    logic        in_valid = 0, in_mode64 = 1, in_gpr = 1, in_idx_en = 0;
    logic [2:0]  in_op = 0;
    logic [1:0]  in_size = 3, in_am = 0, in_scale = 0;
    logic [3:0]  in_base = 0, in_idx = 0, in_wr_reg = 0;
    logic [15:0] in_disp = 0;
    logic [6:0]  in_tag = 0, hit_tag;
    logic [5:0]  in_seq = 0, ret_seq = 0, hit_seq;
    logic        in_wr_en = 0, in_sp_copy = 0, ret_valid = 0;
    logic        vfy_valid = 0, vfy_fwd = 0, hit, flush;
    logic [31:0] vfy_st_addr = 0, vfy_ld_addr = 0;
    int          n_chk = 0, n_err = 0;
    logic        g_hit, g_flush;
    logic [6:0]  g_tag;
    logic [5:0]  g_seq;

    memren_unit u_dut (.*);

    always #2 clk = ~clk;

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", r, act, exp);
        end
    endtask

    task automatic std();
        in_mode64 = 1; in_gpr = 1; in_size = 3; in_am = 0;
        in_idx_en = 0; in_idx = 0; in_scale = 0;
    endtask

    // Drive one instruction at a falling edge and capture the registered result.
    task automatic issue(input logic [2:0] op, input logic [3:0] b, input logic [15:0] d,
                         input logic [6:0] t, input logic [5:0] s);
        in_op = op; in_base = b; in_disp = d; in_tag = t; in_seq = s; in_valid = 1;
        @(negedge clk);
        g_hit = hit; g_tag = hit_tag; g_seq = hit_seq;
        in_valid = 0; in_wr_en = 0; in_sp_copy = 0; ret_valid = 0;
        std();
    endtask

    task automatic exp_hit(input string r, input logic [6:0] t, input logic [5:0] s);
        chk(r, 32'(g_hit), 1);
        if (g_hit) begin
            chk(r, 32'(g_tag), 32'(t));
            chk(r, 32'(g_seq), 32'(s));
        end
    endtask

    task automatic exp_miss(input string r);
        chk(r, 32'(g_hit), 0);
    endtask

    task automatic verify(input logic f, input logic [31:0] sa, input logic [31:0] la);
        vfy_valid = 1; vfy_fwd = f; vfy_st_addr = sa; vfy_ld_addr = la;
        @(negedge clk);
        g_flush = flush; vfy_valid = 0;
    endtask

    initial begin
        #(4 * 150000);
        n_err++;
        $display("FAIL watchdog R13: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic       mv [6];
        logic [6:0] mt [6];
        logic [5:0] ms [6];
        int unsigned r;
        logic [5:0] sq;
        r = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R13 reset hit", 32'(hit), 0);
        chk("R13 reset flush", 32'(flush), 0);

        // R4 basic forward, R5 key differences
        issue(2, 1, 8, 10, 1);
        issue(1, 1, 8, 0, 20);  exp_hit("R4 store to load", 10, 1);
        issue(1, 2, 8, 0, 20);  exp_miss("R5 other base");
        issue(1, 1, 16, 0, 20); exp_miss("R5 other disp");
        in_idx_en = 1; in_idx = 3;
        issue(1, 1, 8, 0, 20);  exp_miss("R5 index added");

        // R1 size and class
        in_size = 1; issue(2, 5, 0, 11, 2);
        issue(1, 5, 0, 0, 20);  exp_miss("R1 16-bit store");
        in_gpr = 0; issue(2, 6, 0, 11, 2);
        issue(1, 6, 0, 0, 20);  exp_miss("R1 non-gpr store");
        in_size = 1; issue(1, 1, 8, 0, 20); exp_miss("R1 16-bit load");

        // R2 addressing modes
        in_am = 1; issue(2, 7, 0, 12, 3);
        in_am = 1; issue(1, 7, 0, 0, 20); exp_miss("R2 absolute");
        issue(1, 7, 0, 0, 20);  exp_miss("R2 absolute store no entry");
        in_am = 2; issue(2, 7, 8, 12, 3);
        in_am = 2; issue(1, 7, 8, 0, 20); exp_miss("R2 ip-relative");

        // R3 displacement alignment
        issue(2, 8, 4, 13, 4);
        issue(1, 8, 4, 0, 20);  exp_miss("R3 mode64 disp 4");
        in_mode64 = 0; issue(2, 8, 4, 13, 4);
        in_mode64 = 0; issue(1, 8, 4, 0, 20); exp_hit("R3 mode32 disp 4", 13, 4);

        // R9 read-modify-write chain
        issue(3, 1, 8, 20, 12); exp_hit("R9 rmw old tag", 10, 1);
        issue(3, 1, 8, 21, 13); exp_hit("R9 rmw chained", 20, 12);
        issue(1, 1, 8, 0, 20);  exp_hit("R9 load after rmw", 21, 13);

        // R8 register write invalidation
        in_wr_en = 1; in_wr_reg = 1; issue(0, 0, 0, 0, 20);
        issue(1, 1, 8, 0, 20);  exp_miss("R8 base written");
        in_mode64 = 0; issue(1, 8, 4, 0, 20); exp_hit("R8 other entry kept", 13, 4);

        // R6 stack delta tracking
        issue(4, 0, 0, 30, 5);
        issue(6, 0, 0, 0, 20);
        issue(1, 4, 8, 0, 20);  exp_hit("R6 push call load sp+8", 30, 5);
        issue(7, 0, 0, 0, 20);
        issue(5, 0, 0, 0, 20);  exp_hit("R6 pop after ret", 30, 5);
        issue(2, 4, 0, 31, 6);
        issue(1, 4, 0, 0, 20);  exp_hit("R6 sp based store", 31, 6);

        // R7 stack invalidation
        issue(2, 9, 0, 32, 7);
        in_sp_copy = 1; issue(0, 0, 0, 0, 20);
        issue(1, 4, 0, 0, 20);  exp_miss("R7 sp copy");
        issue(1, 9, 0, 0, 20);  exp_hit("R7 non-sp kept", 32, 7);
        issue(2, 4, 8, 33, 8);
        in_wr_en = 1; in_wr_reg = 4; issue(0, 0, 0, 0, 20);
        issue(1, 4, 8, 0, 20);  exp_miss("R7 sp written");

        // R12 retirement
        issue(2, 10, 0, 40, 9);
        ret_valid = 1; ret_seq = 9; issue(0, 0, 0, 0, 20);
        issue(1, 10, 0, 0, 20); exp_miss("R12 retired");
        issue(1, 9, 0, 0, 20);  exp_hit("R12 other kept", 32, 7);

        // R10 overwrite
        issue(2, 11, 0, 41, 10);
        issue(2, 11, 0, 42, 11);
        ret_valid = 1; ret_seq = 10; issue(0, 0, 0, 0, 20);
        issue(1, 11, 0, 0, 20); exp_hit("R10 overwrite single entry", 42, 11);

        // R11 verification
        verify(1, 100, 100); chk("R11 good forward", 32'(g_flush), 0);
        issue(1, 11, 0, 0, 20); exp_hit("R11 table kept", 42, 11);
        verify(1, 100, 104); chk("R11 bad forward flush", 32'(g_flush), 1);
        @(negedge clk);      chk("R11 one cycle", 32'(flush), 0);
        issue(1, 11, 0, 0, 20); exp_miss("R11 cleared");

        // R10 round robin from slot 0
        for (int i = 0; i < 8; i++) issue(2, 4'((i < 3) ? i + 1 : i + 2), 0, 7'(50 + i), 6'(30 + i));
        issue(2, 12, 0, 60, 40);
        issue(1, 1, 0, 0, 20);  exp_miss("R10 oldest evicted");
        issue(1, 2, 0, 0, 20);  exp_hit("R10 second kept", 51, 31);
        issue(1, 12, 0, 0, 20); exp_hit("R10 new entry", 60, 40);
        verify(0, 200, 200); chk("R11 missed alias flush", 32'(g_flush), 1);
        @(negedge clk);

        // Random store, load, rmw mix on six keys (R4 R9 R10)
        for (int k = 0; k < 6; k++) mv[k] = 0;
        sq = 0;
        for (int n = 0; n < 300; n++) begin
            int k, t;
            logic [6:0] tg;
            k = int'($urandom % 6); t = int'($urandom % 3); tg = 7'($urandom);
            sq = sq + 1;
            issue((t == 0) ? 3'd2 : (t == 1) ? 3'd1 : 3'd3, 4'(1 + k / 2), 16'((k % 2) * 8), tg, sq);
            if (t != 0) begin
                if (mv[k]) exp_hit("R4 random", mt[k], ms[k]);
                else exp_miss("R5 random");
            end
            if (t != 1) begin mv[k] = 1; mt[k] = tg; ms[k] = sq; end
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule